// File: doc/BRIEF.md
# Oversampled UART Receive Bit Sampler

This block turns an asynchronous serial line into received characters. A clock enable running at sixteen times the bit rate times everything. The input first passes through a synchroniser chain. The receiver then waits for the line to go low. It confirms the start bit half a bit later, and takes every later bit at its centre. The result is a byte together with framing, parity and break indications and a one-cycle valid strobe. Buffering of characters, host access and bit-rate generation belong to neighbouring blocks.

The data width is fixed by a two-bit length select: 00 means five data bits, 01 six, 10 seven and 11 eight. An enable turns a parity bit on after the data, and a second input chooses odd or even parity. The configuration must stay stable while a character is in flight. The character outputs hold their values until the next strobe.

Top module: `uart_rx_sampler`

## Requirements
- R1: While reset is active and after it is released, rx_valid, rx_data, rx_frame_err, rx_par_err and rx_break are all 0.
- R2: A character is reported by rx_valid being high for exactly one clock. Data bits arrive least significant first, and rx_data[0] is the first bit received after the start bit.
- R3: cfg_wlen selects 5, 6, 7 or 8 data bits (00, 01, 10, 11). For lengths below 8, the rx_data bits above the word are 0.
- R4: When cfg_par_en is 1, one parity bit follows the data. rx_par_err is 1 when the ones in data plus parity are odd with cfg_par_odd=0, or even with cfg_par_odd=1. With cfg_par_en=0, rx_par_err stays 0.
- R5: rx_frame_err is 1 exactly when the stop bit sampled at its centre is 0.
- R6: rx_break is 1 when all data bits, the parity bit (if enabled) and the stop bit were 0. It is then reported together with rx_frame_err and rx_data=0.
- R7: A low pulse on the line that has gone high again by the confirmation point, 8 ticks after the edge, produces no character. The receiver goes back to hunting, and the next real character is received correctly.
- R8: After a character, no new start is hunted until the line has been seen high. A line held low after a break yields exactly one character.
- R9: All bit timing counts os_tick enables rather than clock cycles. A tick every other clock receives correctly at double the bit period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | Oversampling enable, 16 per bit |
| rx_in | input | 1 | Asynchronous serial line, idle high |
| cfg_wlen | input | 2 | Data length select (00=5 ... 11=8) |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even |
| rx_data | output | 8 | Received character, zero-extended |
| rx_valid | output | 1 | One-cycle character strobe |
| rx_frame_err | output | 1 | Stop bit sampled low |
| rx_par_err | output | 1 | Parity mismatch |
| rx_break | output | 1 | All-zero frame |

## Verification
A frame that is entirely zero raises the framing error and the break indication on the same strobe. When parity is enabled, the parity check is evaluated on that strobe too. The bench provokes this with an all-zero byte under even parity and a low stop bit. It expects rx_frame_err and rx_break together with rx_par_err clear, because a zero parity bit is correct for zero data. A second case flips the parity bit of a framed character. There the bench expects the parity error alone and no break.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
   localparam int DATA_W = 8;

   typedef enum logic [2:0] {
      ST_WAIT_HIGH,
      ST_HUNT,
      ST_START,
      ST_DATA,
      ST_PARITY,
      ST_STOP
   } rx_state_e;

   // length select 00..11 -> 5..8 data bits
   function automatic logic [3:0] word_bits(input logic [1:0] sel);
      return 4'd5 + {2'b00, sel};
   endfunction
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_in,
   output logic d_out
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad
         $error("rx_sync needs at least two stages");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], d_in};
   end

   assign d_out = chain[STAGES-1];
endmodule

// File: rtl/rx_bit_timer.sv
module rx_bit_timer #(
   parameter int OVERSAMPLE = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic clear,
   input  logic half_sel,
   output logic due
);
   localparam int CW   = $clog2(OVERSAMPLE);
   localparam int HALF = OVERSAMPLE / 2;

   logic [CW-1:0] cnt;
   logic [CW-1:0] limit;

   generate
      if (OVERSAMPLE < 4 || (OVERSAMPLE % 2) != 0) begin : g_bad
         $error("OVERSAMPLE must be even and at least 4");
      end
   endgenerate

   assign limit = half_sel ? CW'(HALF - 1) : CW'(OVERSAMPLE - 1);
   assign due   = tick && !clear && (cnt == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt <= '0;
      else if (clear || due) cnt <= '0;
      else if (tick)         cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
   import uart_rx_pkg::*;
#(
   parameter int DW = DATA_W
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          line,
   input  logic          due,
   input  logic [1:0]    wlen,
   input  logic          par_en,
   input  logic          par_odd,
   output logic          cnt_clear,
   output logic          half_sel,
   output logic [DW-1:0] data_o,
   output logic          valid_o,
   output logic          fe_o,
   output logic          pe_o,
   output logic          brk_o
);
   localparam int IW = $clog2(DW);

   rx_state_e     state;
   logic [DW-1:0] sh;
   logic [IW-1:0] bit_idx;
   logic [IW-1:0] last_idx;
   logic          pbit;

   assign last_idx  = IW'(word_bits(wlen) - 4'd1);
   assign cnt_clear = (state == ST_WAIT_HIGH) || (state == ST_HUNT);
   assign half_sel  = (state == ST_START);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_WAIT_HIGH;
         sh      <= '0;
         bit_idx <= '0;
         pbit    <= 1'b0;
         data_o  <= '0;
         valid_o <= 1'b0;
         fe_o    <= 1'b0;
         pe_o    <= 1'b0;
         brk_o   <= 1'b0;
      end else begin
         valid_o <= 1'b0;
         case (state)
            ST_WAIT_HIGH: if (line) state <= ST_HUNT;
            ST_HUNT: if (tick && !line) begin
               state   <= ST_START;
               sh      <= '0;
               bit_idx <= '0;
               pbit    <= 1'b0;
            end
            ST_START: if (due) state <= line ? ST_HUNT : ST_DATA;
            ST_DATA: if (due) begin
               sh[bit_idx] <= line;
               if (bit_idx == last_idx) state <= par_en ? ST_PARITY : ST_STOP;
               else                     bit_idx <= bit_idx + 1'b1;
            end
            ST_PARITY: if (due) begin
               pbit  <= line;
               state <= ST_STOP;
            end
            ST_STOP: if (due) begin
               valid_o <= 1'b1;
               data_o  <= sh;
               fe_o    <= !line;
               pe_o    <= par_en && ((^sh ^ pbit) != par_odd);
               brk_o   <= !line && (sh == '0) && !(par_en && pbit);
               state   <= ST_WAIT_HIGH;
            end
            default: state <= ST_WAIT_HIGH;
         endcase
      end
   end
endmodule

// File: rtl/uart_rx_sampler.sv
module uart_rx_sampler
   import uart_rx_pkg::*;
#(
   parameter int OVERSAMPLE  = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              os_tick,
   input  logic              rx_in,
   input  logic [1:0]        cfg_wlen,
   input  logic              cfg_par_en,
   input  logic              cfg_par_odd,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_valid,
   output logic              rx_frame_err,
   output logic              rx_par_err,
   output logic              rx_break
);
   logic line_s;
   logic due;
   logic cnt_clear;
   logic half_sel;

   rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (rx_in),
      .d_out (line_s)
   );

   rx_bit_timer #(.OVERSAMPLE(OVERSAMPLE)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (os_tick),
      .clear    (cnt_clear),
      .half_sel (half_sel),
      .due      (due)
   );

   rx_frame_fsm #(.DW(DATA_W)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (os_tick),
      .line      (line_s),
      .due       (due),
      .wlen      (cfg_wlen),
      .par_en    (cfg_par_en),
      .par_odd   (cfg_par_odd),
      .cnt_clear (cnt_clear),
      .half_sel  (half_sel),
      .data_o    (rx_data),
      .valid_o   (rx_valid),
      .fe_o      (rx_frame_err),
      .pe_o      (rx_par_err),
      .brk_o     (rx_break)
   );
endmodule

// File: rtl/uart_rx_sampler_chk.sv
module uart_rx_sampler_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] cfg_wlen,
   input logic       cfg_par_en,
   input logic [7:0] rx_data,
   input logic       rx_valid,
   input logic       rx_frame_err,
   input logic       rx_par_err,
   input logic       rx_break
);
   // R2
   valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);

   // R6
   break_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && rx_break) |-> rx_frame_err);

   // R6
   break_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && rx_break) |-> (rx_data == 8'h00));

   // R3
   short_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && cfg_wlen == 2'b00) |-> (rx_data[7:5] == 3'b000));

   // R4
   parity_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && !cfg_par_en) |-> !rx_par_err);

   // R1
   reset_quiet_chk: assert property (@(posedge clk)
      !rst_n |=> !rx_valid);
endmodule

bind uart_rx_sampler uart_rx_sampler_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cfg_wlen     (cfg_wlen),
   .cfg_par_en   (cfg_par_en),
   .rx_data      (rx_data),
   .rx_valid     (rx_valid),
   .rx_frame_err (rx_frame_err),
   .rx_par_err   (rx_par_err),
   .rx_break     (rx_break)
);

// File: tb/uart_rx_sampler_test.sv
module uart_rx_sampler_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       os_tick = 1'b0;
   logic       rx_in = 1'b1;
   logic [1:0] cfg_wlen = 2'b11;
   logic       cfg_par_en = 1'b0;
   logic       cfg_par_odd = 1'b0;
   logic [7:0] rx_data;
   logic       rx_valid;
   logic       rx_frame_err;
   logic       rx_par_err;
   logic       rx_break;

   int errors = 0;
   int checks = 0;
   int div = 1;
   int tick_cnt = 0;
   int vcount = 0;
   logic [7:0] c_data;
   logic c_fe, c_pe, c_brk;
   bit done = 0;

   always #2.5 clk = ~clk;

   uart_rx_sampler uut (
      .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_in(rx_in),
      .cfg_wlen(cfg_wlen), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
      .rx_data(rx_data), .rx_valid(rx_valid), .rx_frame_err(rx_frame_err),
      .rx_par_err(rx_par_err), .rx_break(rx_break)
   );

   // tick generator: one enable every div clocks
   always @(negedge clk) begin
      os_tick  <= (tick_cnt == 0);
      tick_cnt <= (tick_cnt + 1 >= div) ? 0 : tick_cnt + 1;
   end

   // capture character strobes
   always @(negedge clk) begin
      if (rst_n && rx_valid) begin
         vcount++;
         c_data = rx_data;
         c_fe   = rx_frame_err;
         c_pe   = rx_par_err;
         c_brk  = rx_break;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic hold_bits(input int n);
      repeat (n * 16 * div) @(negedge clk);
   endtask

   // [13:12] length, [11] par_en, [10] par_odd, [9:2] data, [1] flip parity, [0] stop
   localparam logic [13:0] VEC [8] = '{
      {2'b11, 1'b0, 1'b0, 8'hA5, 1'b0, 1'b1},
      {2'b11, 1'b0, 1'b0, 8'h3C, 1'b0, 1'b1},
      {2'b00, 1'b0, 1'b0, 8'hFF, 1'b0, 1'b1},
      {2'b01, 1'b1, 1'b0, 8'h2A, 1'b0, 1'b1},
      {2'b10, 1'b1, 1'b1, 8'h55, 1'b1, 1'b1},
      {2'b11, 1'b1, 1'b0, 8'h81, 1'b1, 1'b1},
      {2'b11, 1'b0, 1'b0, 8'hC3, 1'b0, 1'b0},
      {2'b11, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0}
   };

   task automatic send(input logic [1:0] wl, input bit pen, input bit podd,
                       input logic [7:0] d, input bit flip, input bit stop,
                       input int extra_low);
      logic [7:0] m;
      bit pb;
      m = d & (8'hFF >> (3 - wl));
      pb = (^m) ^ podd ^ flip;
      cfg_wlen = wl; cfg_par_en = pen; cfg_par_odd = podd;
      rx_in = 1'b0; hold_bits(1);
      for (int i = 0; i < 5 + wl; i++) begin
         rx_in = d[i]; hold_bits(1);
      end
      if (pen) begin rx_in = pb; hold_bits(1); end
      rx_in = stop; hold_bits(1 + extra_low);
      rx_in = 1'b1; hold_bits(2);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=1 expected=0");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      // R1 reset state
      check(rx_valid == 0 && rx_data == 0 && !rx_frame_err && !rx_par_err && !rx_break,
            "R1 in reset", {rx_valid, rx_data}, 0);
      rst_n = 1'b1;
      repeat (20) @(negedge clk);
      check(rx_valid == 0 && rx_data == 0 && !rx_break, "R1 after reset", {rx_valid, rx_data}, 0);

      // table walk: R2 R3 R4 R5 R6
      foreach (VEC[k]) begin
         logic [1:0] wl; bit pen, podd, flip, stp; logic [7:0] d, m; bit pb;
         {wl, pen, podd, d, flip, stp} = VEC[k];
         m  = d & (8'hFF >> (3 - wl));
         pb = (^m) ^ podd ^ flip;
         vcount = 0;
         send(wl, pen, podd, d, flip, stp, 0);
         check(vcount == 1, "R2 one strobe", vcount, 1);
         check(c_data == m, "R2/R3 data", c_data, m);
         check(c_pe == (pen && flip), "R4 parity err", c_pe, pen && flip);
         check(c_fe == !stp, "R5 frame err", c_fe, !stp);
         check(c_brk == (m == 0 && !stp && !(pen && pb)), "R6 break", c_brk,
               (m == 0 && !stp && !(pen && pb)));
      end

      // R7 false start of 5 clocks
      vcount = 0;
      cfg_wlen = 2'b11; cfg_par_en = 0;
      rx_in = 1'b0; repeat (5) @(negedge clk);
      rx_in = 1'b1; hold_bits(3);
      check(vcount == 0, "R7 glitch ignored", vcount, 0);
      send(2'b11, 0, 0, 8'h5A, 0, 1, 0);
      check(vcount == 1 && c_data == 8'h5A, "R7 next char", c_data, 8'h5A);

      // R8 break with line held low afterwards
      vcount = 0;
      send(2'b11, 0, 0, 8'h00, 0, 0, 4);
      check(vcount == 1, "R8 single char on long low", vcount, 1);
      check(c_brk && c_fe, "R8 break reported", {c_brk, c_fe}, 3);
      vcount = 0;
      send(2'b11, 0, 0, 8'hE7, 0, 1, 0);
      check(vcount == 1 && c_data == 8'hE7, "R8 recovery", c_data, 8'hE7);

      // R9 tick every second clock
      div = 2;
      hold_bits(1);
      vcount = 0;
      send(2'b11, 0, 0, 8'h96, 0, 1, 0);
      check(vcount == 1 && c_data == 8'h96 && !c_fe, "R9 half-rate tick", c_data, 8'h96);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule